// File: doc/BRIEF.md
# Supply and watchdog reset supervisor

A synchronous supervisor that drives one system reset output from two causes. The first cause is a digital supply-good flag. While it reads low the reset is held, and once it reads high again the reset stays on for a fixed stretch. The second cause is a watchdog that observes an active-low chip-select line. A falling edge of chip select restarts the watchdog. If the line sits at either level longer than the selected timeout, the watchdog fires the same stretched reset.

The reset pin is modelled as open drain. One output says when the pin pulls, and a second gives the level it would carry, so its polarity is a build parameter. Watchdog settings live in a small control register that is written through a strobe and a data word. A write-protect pin combined with a protect-enable bit freezes that register. Supply-good and chip select each pass through a two-flop synchronizer before anything else uses them.

Top module: `supply_wdog_supervisor`

## Requirements
- R1: While the synchronized supply-good flag is low, the reset output is asserted; a low level on `supply_ok_i` asserts it at the third rising clock edge after it is applied.
- R2: Once the synchronized supply-good flag is high, reset is released after exactly `HOLD_CYC` further cycles. Measured from the input rising, this is `HOLD_CYC`+2 edges.
- R3: Reset is asserted during and after the synchronous reset `rst_n`, and it stays asserted until supply is good and the R2 stretch has completed.
- R4: The control word `cfg_wdata_i` has these fields: bits [1:0] are the timeout code, bit 2 is the watchdog enable and bit 3 is protect-enable. With the enable at 1, code 00 selects `TMO0` cycles, 01 selects `TMO1` and 10 selects `TMO2`. If chip select holds either level for that many cycles without a falling edge, reset is asserted.
- R5: A falling edge of the synchronized chip select clears the watchdog count. A rising edge leaves the count running.
- R6: A watchdog-triggered reset is stretched for `HOLD_CYC` cycles. The watchdog count stays at zero while reset is asserted and starts again from zero when reset is released.
- R7: `rst_oe_o` is 1 exactly when reset is asserted. `rst_lvl_o` equals `RST_ACTIVE_HIGH` while asserted and its inverse otherwise.
- R8: When `wp_n_i` is 0 and the stored protect-enable bit is 1, control writes change no field, including protect-enable itself. Otherwise a write takes effect at the strobe's clock edge. After `rst_n` every field is 0.
- R9: While supply-good is low, the watchdog count is held at zero. After recovery, a full timeout is therefore needed before the next watchdog reset.
- R10: With timeout code 11, or with the enable bit at 0, the watchdog never asserts reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag, asynchronous |
| cs_n_i | input | 1 | Active-low chip select watched by the watchdog, asynchronous |
| wp_n_i | input | 1 | Active-low write-protect pin |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 4 | Control write data: [1:0] timeout code, [2] enable, [3] protect-enable |
| rst_oe_o | output | 1 | Open-drain pull enable, 1 while reset is asserted |
| rst_lvl_o | output | 1 | Level of the reset pin at the selected polarity |

## Verification
Chip select is tried in several patterns, and each one separates a different fault. Holding the line high and holding it low shows that both stuck levels time out. A fall followed by a rise partway through the window shows whether a rising edge wrongly restarts the count, because the trip lands exactly one timeout after the fall. A steady fall period shorter than the timeout shows that keep-alive works. The supply is dropped while the watchdog is armed, and the measured release-to-trip distance shows whether the count was held at zero. Writes under lock, both to disable the watchdog and to clear protect-enable, are judged by whether the running watchdog still fires on time.

// File: rtl/sup_pkg.sv
// Shared types for the reset supervisor: control word layout and timeout codes.
package sup_pkg;
    localparam logic [1:0] TSEL_OFF = 2'b11;

    typedef struct packed {
        logic       prot_en;
        logic       wd_en;
        logic [1:0] tsel;
    } sup_cfg_t;

    localparam int CFG_W = $bits(sup_cfg_t);
endpackage

// File: rtl/sup_sync.sv
// Bank of two-flop synchronizers, one per bit.
// Assumes: inputs are quasi-static relative to clk; RST_VAL gives each bit's idle value.
module sup_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stg;
        // Shift the asynchronous bit through two stages.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {2{RST_VAL[i]}};
            else        stg <= {stg[0], d[i]};
        end
        assign q[i] = stg[1];
    end
endmodule

// File: rtl/sup_cfg_reg.sv
// Watchdog control register with write-protect lock.
// Assumes: we and wdata are synchronous to clk; wp_n low plus stored prot_en locks all fields.
module sup_cfg_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  sup_pkg::sup_cfg_t wdata,
    input  logic              wp_n,
    output sup_pkg::sup_cfg_t cfg
);
    logic locked;

    // Lock applies when the pin is active and protection is armed.
    assign locked = !wp_n && cfg.prot_en;

    // Accept a write only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                cfg <= '0;
        else if (we && !locked)    cfg <= wdata;
    end
endmodule

// File: rtl/sup_wdog.sv
// Chip-select activity watchdog.
// Assumes: cs_s and ok_s are already synchronized; hold_on is the current reset state.
// A falling edge of cs_s restarts the count; trip pulses for one cycle at timeout.
module sup_wdog #(
    parameter int TMO0  = 8,
    parameter int TMO1  = 16,
    parameter int TMO2  = 32,
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              ok_s,
    input  logic              hold_on,
    input  sup_pkg::sup_cfg_t cfg,
    output logic              trip,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(TMO0 - 1);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(TMO1 - 1);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(TMO2 - 1);

    logic             cs_q;
    logic             fall;
    logic             active;
    logic             run;
    logic [CNT_W-1:0] lim;

    // Remember the previous chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_s;
    end

    assign fall   = cs_q && !cs_s;
    assign active = cfg.wd_en && (cfg.tsel != sup_pkg::TSEL_OFF);
    assign run    = active && ok_s && !hold_on && !fall;

    // Pick the terminal count for the selected timeout code.
    always_comb begin
        case (cfg.tsel)
            2'b00:   lim = LIM0;
            2'b01:   lim = LIM1;
            default: lim = LIM2;
        endcase
    end

    assign trip = run && (cnt >= lim);

    // Count idle cycles; clear on edge, trip, reset, supply loss or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || trip) cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/sup_stretch.sv
// Reset stretcher shared by both reset causes.
// Assumes: ok_s is synchronized; trip is a single-cycle pulse issued only while released.
module sup_stretch #(
    parameter int HOLD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_s,
    input  logic trip,
    output logic asrt
);
    localparam int             HW   = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HW-1:0]  LAST = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hcnt;

    // Assert on supply loss or trip, release after HOLD_CYC good cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asrt <= 1'b1;
            hcnt <= '0;
        end else if (!ok_s || trip) begin
            asrt <= 1'b1;
            hcnt <= '0;
        end else if (asrt) begin
            if (hcnt == LAST) begin
                asrt <= 1'b0;
                hcnt <= '0;
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end
endmodule

// File: rtl/supply_wdog_supervisor.sv
// Top of the supply and watchdog reset supervisor.
// Assumes: supply_ok_i and cs_n_i are asynchronous; configuration inputs are synchronous.
// The reset pin is open drain: rst_oe_o pulls, rst_lvl_o carries the polarity.
module supply_wdog_supervisor #(
    parameter int HOLD_CYC        = 10_000_000,
    parameter int TMO0            = 7_500_000,
    parameter int TMO1            = 30_000_000,
    parameter int TMO2            = 70_000_000,
    parameter bit RST_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       cs_n_i,
    input  logic       wp_n_i,
    input  logic       cfg_we_i,
    input  logic [3:0] cfg_wdata_i,
    output logic       rst_oe_o,
    output logic       rst_lvl_o
);
    localparam int MAX01 = (TMO0 > TMO1) ? TMO0 : TMO1;
    localparam int MAXT  = (MAX01 > TMO2) ? MAX01 : TMO2;
    localparam int CNT_W = $clog2(MAXT + 1);

    logic              ok_s;
    logic              cs_s;
    logic              trip;
    logic              asrt;
    logic [CNT_W-1:0]  wd_cnt;
    sup_pkg::sup_cfg_t cfg;

    sup_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_i, supply_ok_i}),
        .q     ({cs_s, ok_s})
    );

    sup_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we_i),
        .wdata (sup_pkg::sup_cfg_t'(cfg_wdata_i)),
        .wp_n  (wp_n_i),
        .cfg   (cfg)
    );

    sup_wdog #(.TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2), .CNT_W(CNT_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .ok_s    (ok_s),
        .hold_on (asrt),
        .cfg     (cfg),
        .trip    (trip),
        .cnt     (wd_cnt)
    );

    sup_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .ok_s  (ok_s),
        .trip  (trip),
        .asrt  (asrt)
    );

    assign rst_oe_o = asrt;

    if (RST_ACTIVE_HIGH) begin : g_act_hi
        assign rst_lvl_o = asrt;
    end else begin : g_act_lo
        assign rst_lvl_o = !asrt;
    end
endmodule

// File: rtl/sup_checks.sv
// Assertion checker bound into the supervisor top.
// Assumes: sees the synchronized inputs, the reset state, the watchdog count and the control word.
module sup_checks #(
    parameter int HOLD_CYC = 20,
    parameter int CNT_W    = 6,
    parameter bit ACT_HIGH = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ok_s,
    input logic             cs_s,
    input logic             asrt,
    input logic             lvl,
    input logic [CNT_W-1:0] wd_cnt,
    input logic [3:0]       cfg,
    input logic             cfg_we,
    input logic             wp_n
);
    logic cs_prev;
    int   good_run;

    // Own copy of the previous chip-select level.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_s;
    end

    // Count consecutive cycles that reset is held with supply good.
    always_ff @(posedge clk) begin
        if (!rst_n || !ok_s || !asrt) good_run <= 0;
        else                          good_run <= good_run + 1;
    end

    a_r1_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_s |=> asrt);

    a_r2_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asrt) |-> (good_run == HOLD_CYC));

    a_r5_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_prev && !cs_s) |=> (wd_cnt == '0));

    a_r6_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        asrt |=> (wd_cnt == '0));

    a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
        asrt |-> (lvl == ACT_HIGH));

    a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wp_n && cfg[3]) |=> $stable(cfg));

    a_r9_supply_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_s |=> (wd_cnt == '0));

    a_r10_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[2] || (cfg[1:0] == 2'b11)) |=> (wd_cnt == '0));
endmodule

bind supply_wdog_supervisor sup_checks #(
    .HOLD_CYC (HOLD_CYC),
    .CNT_W    (CNT_W),
    .ACT_HIGH (RST_ACTIVE_HIGH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ok_s   (ok_s),
    .cs_s   (cs_s),
    .asrt   (rst_oe_o),
    .lvl    (rst_lvl_o),
    .wd_cnt (wd_cnt),
    .cfg    (cfg),
    .cfg_we (cfg_we_i),
    .wp_n   (wp_n_i)
);

// File: tb/sim_supply_wdog_supervisor.sv
// Bench: behavioural reference model compared every clock, plus directed timing checks.
module sim_supply_wdog_supervisor;
    localparam int HOLD = 20;
    localparam int T0   = 8;
    localparam int T1   = 16;
    localparam int T2   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       cs_n = 1'b1;
    logic       wp_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic       oe0, lvl0, oe1, lvl1;

    int    checks = 0;
    int    errors = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R3";

    always #10 clk = ~clk;

    supply_wdog_supervisor #(.HOLD_CYC(HOLD), .TMO0(T0), .TMO1(T1), .TMO2(T2),
                             .RST_ACTIVE_HIGH(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .cs_n_i(cs_n),
        .wp_n_i(wp_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .rst_oe_o(oe0), .rst_lvl_o(lvl0));

    supply_wdog_supervisor #(.HOLD_CYC(HOLD), .TMO0(T0), .TMO1(T1), .TMO2(T2),
                             .RST_ACTIVE_HIGH(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .cs_n_i(cs_n),
        .wp_n_i(wp_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .rst_oe_o(oe1), .rst_lvl_o(lvl1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    int m_ok1, m_ok2, m_cs1, m_cs2, m_csp, m_asrt, m_hold, m_wd;
    int m_tsel, m_en, m_prot;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ok1 = 0; m_ok2 = 0; m_cs1 = 1; m_cs2 = 1; m_csp = 1;
            m_asrt = 1; m_hold = 0; m_wd = 0;
            m_tsel = 0; m_en = 0; m_prot = 0;
        end else begin
            int lim;
            bit fall, act, run, trip;
            fall = (m_csp == 1) && (m_cs2 == 0);
            act  = (m_en == 1) && (m_tsel != 3);
            lim  = (m_tsel == 0) ? T0 : (m_tsel == 1) ? T1 : T2;
            run  = act && (m_ok2 == 1) && (m_asrt == 0) && !fall;
            trip = run && (m_wd >= lim - 1);
            if (m_ok2 == 0 || trip) begin
                m_asrt = 1; m_hold = 0;
            end else if (m_asrt == 1) begin
                if (m_hold == HOLD - 1) begin m_asrt = 0; m_hold = 0; end
                else m_hold++;
            end
            if (!run || trip) m_wd = 0; else m_wd++;
            if (cfg_we && !(wp_n == 1'b0 && m_prot == 1)) begin
                m_tsel = int'(cfg_wdata[1:0]);
                m_en   = int'(cfg_wdata[2]);
                m_prot = int'(cfg_wdata[3]);
            end
            m_csp = m_cs2; m_cs2 = m_cs1; m_cs1 = int'(cs_n);
            m_ok2 = m_ok1; m_ok1 = int'(supply_ok);
        end
        started = 1'b1;
    end

    // Compare both instances against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, int'(oe0), m_asrt);
            chk("R7", int'(oe1), m_asrt);
            chk("R7", int'(lvl0), 1 - m_asrt);
            chk("R7", int'(lvl1), m_asrt);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_oe(input logic want, output int n);
        n = 0;
        while (oe0 !== want && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        tick(5);
        chk("R3", int'(oe0), 1);
        rst_n = 1'b1;
        tick(5);
        chk("R3", int'(oe0), 1);
        cur_req = "R2";
        supply_ok = 1'b1;
        wait_oe(1'b0, n);
        chk("R2", n, HOLD + 2);

        cur_req = "R10";
        tick(3 * T2);
        chk("R10", int'(oe0), 0);
        wr(4'b0111);
        tick(3 * T2);
        chk("R10", int'(oe0), 0);

        cur_req = "R4";
        wr(4'b0100);
        wait_oe(1'b1, n);
        chk("R4", n, T0);
        cur_req = "R6";
        wait_oe(1'b0, n);
        chk("R6", n, HOLD);
        wait_oe(1'b1, n);
        chk("R6", n, T0);
        wait_oe(1'b0, n);

        cur_req = "R4";
        cs_n = 1'b0;
        wr(4'b0101);
        wait_oe(1'b1, n);
        chk("R4", n + 1, T1 + 3);
        wait_oe(1'b0, n);

        cur_req = "R5";
        cs_n = 1'b1;
        tick(3);
        cs_n = 1'b0;
        tick(T1 / 2);
        cs_n = 1'b1;
        wait_oe(1'b1, n);
        chk("R5", n + T1 / 2, T1 + 3);
        wait_oe(1'b0, n);
        for (int i = 0; i < 12; i++) begin
            cs_n = 1'b0;
            tick(T1 / 4);
            cs_n = 1'b1;
            tick(T1 / 4);
        end
        chk("R5", int'(oe0), 0);

        cur_req = "R8";
        wr(4'b1111);
        tick(2);
        wp_n = 1'b0;
        wr(4'b0100);
        tick(3 * T2);
        chk("R8", int'(oe0), 0);
        wp_n = 1'b1;
        wr(4'b0100);
        wait_oe(1'b1, n);
        chk("R8", n, T0);
        wait_oe(1'b0, n);
        wr(4'b1100);
        wp_n = 1'b0;
        wr(4'b0011);
        wait_oe(1'b1, n);
        chk("R8", n, T0 - 2);
        wait_oe(1'b0, n);
        wr(4'b0111);
        wait_oe(1'b1, n);
        chk("R8", n, T0 - 1);
        wait_oe(1'b0, n);

        cur_req = "R1";
        wp_n = 1'b1;
        wr(4'b0101);
        supply_ok = 1'b0;
        tick(2);
        chk("R1", int'(oe0), 0);
        tick(1);
        chk("R1", int'(oe0), 1);
        tick(3 * T2);
        chk("R1", int'(oe0), 1);
        cur_req = "R9";
        supply_ok = 1'b1;
        wait_oe(1'b0, n);
        chk("R2", n, HOLD + 2);
        wait_oe(1'b1, n);
        chk("R9", n, T1);
        wait_oe(1'b0, n);
        chk("R6", n, HOLD);

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule